// File: doc/BRIEF.md
# Serial Field-Memory Write Port

This block is the write half of a sequential-access field store. Each 12-bit word presented on a rising write-clock edge with the write enable high is captured and the write pointer steps by one. Words gather in an eight-slot staging bank. When the bank is full, it is handed to the storage array as one block, together with a per-slot mask. A slot's mask bit is set only if the input enable was high when that word arrived. Slots with a clear mask bit leave the array unchanged.

A write-reset strobe starts a new write sequence and returns the pointer to zero. It is the only event that pushes a partly filled bank into the array. The gate in front of the strobe rejects a strobe that comes too soon after the previous one. The run tracker reports a sequence that ended with too few writes. The array interface is a single block-write strobe with a word address, flat data and a mask. Every array write appears one clock after the edge that completed it, so ports can be cascaded.

The run tracker is a three-state machine:
- `RS_IDLE`: no sequence has started since power-on.
- `RS_RUN`: a sequence is open and has not yet reached the minimum length.
- `RS_MET`: the minimum length has been reached.

Its transitions are:
- IDLE→RUN and MET→RUN on an accepted strobe.
- RUN→MET on the write that reaches the minimum.
- RUN→RUN on an accepted strobe, which also raises the short-sequence flag.

Top module: `field_wr_port`

## Requirements
- R1: While `arst` is high and just after it falls, `wptr_o` is 0, `mem_we_o`, `proto_err_o` and `short_err_o` are 0, and `mem_addr_o` and `mem_mask_o` are 0.
- R2: An accepted write-reset edge (`wr_rst_i` high) clears `wptr_o` to 0 after that edge. On that edge `wr_en_i` and `in_en_i` have no effect.
- R3: On an edge with `wr_en_i` high and no accepted reset, `wptr_o` increments by one, wrapping from 1023 to 0. With `wr_en_i` low, `wptr_o` holds.
- R4: A `wr_rst_i` high edge is accepted only if at least 2 edges with `wr_rst_i` low have been sampled since the previous edge that saw it high. Power-on counts as having met this rule. A rejected request pulses `proto_err_o` for one cycle after that edge and does not clear the pointer. `wr_en_i` acts normally on that edge.
- R5: `in_en_i` affects only the mask. The pointer advances on every write-enabled edge whatever `in_en_i` is, and the mask bit of a word taken with `in_en_i` low is 0.
- R6: The staging slot is `wptr_o[2:0]`. One cycle after the edge that writes slot 7, `mem_we_o` is high for one cycle. In that cycle `mem_addr_o` is the word address of slot 0 (low 3 bits zero), slot i data is at `mem_data_o[12i+11:12i]`, and `mem_mask_o[i]` is the mask of slot i.
- R7: A partly filled bank raises no strobe until an accepted reset. On that reset edge it is committed: `mem_we_o` is high after the edge, `mem_addr_o` is the block's base, and mask bits are set only for slots written with `in_en_i` high.
- R8: On an accepted reset, `short_err_o` pulses for one cycle if fewer than 80 write-enabled edges occurred since the previous accepted reset. It stays low for 80 or more. It stays low on the first accepted reset after power-on.
- R9: A write on the edge that commits a full bank goes into slot 0 of the next block without altering the committed block.
- R10: An accepted reset on the edge that commits a full bank still commits that bank at its own address and clears the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| arst | input | 1 | Asynchronous power-on reset, active high |
| wr_rst_i | input | 1 | Write-reset strobe |
| wr_en_i | input | 1 | Write enable: capture word and advance pointer |
| in_en_i | input | 1 | Input enable: word is stored in the array |
| din_i | input | 12 | Input word |
| wptr_o | output | 10 | Write address pointer |
| mem_we_o | output | 1 | Array block-write strobe |
| mem_addr_o | output | 10 | Word address of slot 0 of the block |
| mem_data_o | output | 96 | Eight staged words, slot i at bits 12i+11:12i |
| mem_mask_o | output | 8 | Per-slot write mask |
| proto_err_o | output | 1 | Rejected reset request pulse |
| short_err_o | output | 1 | Short write sequence pulse |

## Verification
The commit of a full bank falls on the edge after slot 7 is written. On that same edge a new word can arrive, or a reset strobe can. The bench provokes the first case by keeping the write enable high straight through a block boundary. It then checks that the committed data holds the old eight words and that the next commit carries the new word in slot 0. For the second case it strobes reset immediately after the eighth write. It judges that the full bank appears at its own address with a full mask while the pointer reads zero.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
    typedef enum logic [1:0] {
        RS_IDLE,
        RS_RUN,
        RS_MET
    } run_st_e;
endpackage

// File: rtl/fwp_rst_gate.sv
module fwp_rst_gate #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic req,
    output logic ok,
    output logic err_q
);
    localparam int CW = $clog2(GAP + 1);

    logic [CW-1:0] lo_cnt;
    logic          bad;

    // accepted only after enough sampled low edges
    assign ok  = req && (lo_cnt >= CW'(GAP));
    assign bad = req && !ok;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            lo_cnt <= CW'(GAP);
            err_q  <= 1'b0;
        end else begin
            err_q <= bad;
            if (req)
                lo_cnt <= '0;
            else if (lo_cnt < CW'(GAP))
                lo_cnt <= lo_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fwp_run_fsm.sv
module fwp_run_fsm
    import fwp_pkg::*;
#(
    parameter int MIN_RUN = 80
) (
    input  logic clk,
    input  logic arst,
    input  logic rst_ok,
    input  logic wr_acc,
    output logic short_q
);
    localparam int CW = $clog2(MIN_RUN + 1);

    run_st_e       state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          short_d;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
            short_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            short_q <= short_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        short_d = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (rst_ok) begin
                    state_d = RS_RUN;
                    cnt_d   = '0;
                end
            end
            RS_RUN: begin
                if (rst_ok) begin
                    short_d = 1'b1;
                    cnt_d   = '0;
                end else if (wr_acc) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CW'(MIN_RUN - 1))
                        state_d = RS_MET;
                end
            end
            RS_MET: begin
                if (rst_ok) begin
                    state_d = RS_RUN;
                    cnt_d   = '0;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end
endmodule

// File: rtl/fwp_stage.sv
module fwp_stage #(
    parameter int DW    = 12,
    parameter int AW    = 10,
    parameter int SLOTS = 8
) (
    input  logic                  clk,
    input  logic                  arst,
    input  logic                  rst_ok,
    input  logic                  wr_acc,
    input  logic                  in_en,
    input  logic [DW-1:0]         din,
    input  logic [AW-1:0]         wptr,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [SLOTS*DW-1:0]   mem_data,
    output logic [SLOTS-1:0]      mem_mask
);
    localparam int SW = $clog2(SLOTS);
    localparam int BW = AW - SW;

    logic [DW-1:0]       word_q [SLOTS];
    logic                msk_q  [SLOTS];
    logic [SLOTS*DW-1:0] data_flat;
    logic [SLOTS-1:0]    mask_flat;
    logic                full_q;
    logic                commit_full, commit_part, commit;
    logic [SW-1:0]       slot;
    logic [BW-1:0]       blk;

    assign slot        = wptr[SW-1:0];
    assign blk         = wptr[AW-1:SW];
    assign commit_full = full_q;
    assign commit_part = rst_ok && !full_q && (slot != '0);
    assign commit      = commit_full || commit_part;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or posedge arst) begin
            if (arst) begin
                word_q[g] <= '0;
                msk_q[g]  <= 1'b0;
            end else if (wr_acc && (slot == SW'(g))) begin
                word_q[g] <= din;
                msk_q[g]  <= in_en;
            end else if (commit) begin
                msk_q[g]  <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            data_flat[i*DW +: DW] = word_q[i];
            mask_flat[i]          = msk_q[i];
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            full_q   <= 1'b0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            mem_mask <= '0;
        end else begin
            full_q <= wr_acc && (slot == SW'(SLOTS - 1));
            mem_we <= commit;
            if (commit) begin
                mem_addr <= {(commit_full ? blk - BW'(1) : blk), SW'(0)};
                mem_data <= data_flat;
                mem_mask <= mask_flat;
            end
        end
    end
endmodule

// File: rtl/field_wr_port.sv
module field_wr_port #(
    parameter int DW      = 12,
    parameter int AW      = 10,
    parameter int SLOTS   = 8,
    parameter int MIN_RUN = 80,
    parameter int GAP     = 2
) (
    input  logic                clk,
    input  logic                arst,
    input  logic                wr_rst_i,
    input  logic                wr_en_i,
    input  logic                in_en_i,
    input  logic [DW-1:0]       din_i,
    output logic [AW-1:0]       wptr_o,
    output logic                mem_we_o,
    output logic [AW-1:0]       mem_addr_o,
    output logic [SLOTS*DW-1:0] mem_data_o,
    output logic [SLOTS-1:0]    mem_mask_o,
    output logic                proto_err_o,
    output logic                short_err_o
);
    logic rst_ok;
    logic wr_acc;

    assign wr_acc = wr_en_i && !rst_ok;

    fwp_rst_gate #(.GAP(GAP)) u_gate (
        .clk   (clk),
        .arst  (arst),
        .req   (wr_rst_i),
        .ok    (rst_ok),
        .err_q (proto_err_o)
    );

    fwp_run_fsm #(.MIN_RUN(MIN_RUN)) u_run (
        .clk     (clk),
        .arst    (arst),
        .rst_ok  (rst_ok),
        .wr_acc  (wr_acc),
        .short_q (short_err_o)
    );

    fwp_stage #(.DW(DW), .AW(AW), .SLOTS(SLOTS)) u_stage (
        .clk      (clk),
        .arst     (arst),
        .rst_ok   (rst_ok),
        .wr_acc   (wr_acc),
        .in_en    (in_en_i),
        .din      (din_i),
        .wptr     (wptr_o),
        .mem_we   (mem_we_o),
        .mem_addr (mem_addr_o),
        .mem_data (mem_data_o),
        .mem_mask (mem_mask_o)
    );

    // pointer wraps naturally at its width
    always_ff @(posedge clk or posedge arst) begin
        if (arst)
            wptr_o <= '0;
        else if (rst_ok)
            wptr_o <= '0;
        else if (wr_en_i)
            wptr_o <= wptr_o + 1'b1;
    end
endmodule

// File: rtl/fwp_chk.sv
module fwp_chk #(
    parameter int AW    = 10,
    parameter int SLOTS = 8
) (
    input logic          clk,
    input logic          arst,
    input logic          wr_rst_i,
    input logic          wr_en_i,
    input logic          rst_ok,
    input logic          wr_acc,
    input logic [AW-1:0] wptr_o,
    input logic          mem_we_o,
    input logic          proto_err_o,
    input logic          short_err_o
);
    localparam int SW = $clog2(SLOTS);

    a_r2_ptr_clear: assert property (@(posedge clk) disable iff (arst)
        rst_ok |=> (wptr_o == '0));

    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (arst)
        (!wr_en_i && !rst_ok) |=> $stable(wptr_o));

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (arst)
        wr_acc |=> (wptr_o == AW'($past(wptr_o) + 1'b1)));

    a_r4_proto_cause: assert property (@(posedge clk) disable iff (arst)
        proto_err_o |-> ($past(wr_rst_i) && !$past(rst_ok)));

    a_r6_full_commit: assert property (@(posedge clk) disable iff (arst)
        (wr_acc && (wptr_o[SW-1:0] == SW'(SLOTS - 1))) |-> ##2 mem_we_o);

    a_r7_flush: assert property (@(posedge clk) disable iff (arst)
        (rst_ok && (wptr_o[SW-1:0] != '0)) |=> mem_we_o);

    a_r8_short_cause: assert property (@(posedge clk) disable iff (arst)
        short_err_o |-> $past(rst_ok));
endmodule

bind field_wr_port fwp_chk #(.AW(AW), .SLOTS(SLOTS)) u_chk (
    .clk         (clk),
    .arst        (arst),
    .wr_rst_i    (wr_rst_i),
    .wr_en_i     (wr_en_i),
    .rst_ok      (rst_ok),
    .wr_acc      (wr_acc),
    .wptr_o      (wptr_o),
    .mem_we_o    (mem_we_o),
    .proto_err_o (proto_err_o),
    .short_err_o (short_err_o)
);

// File: tb/tb_field_wr_port.sv
module tb_field_wr_port;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        arst = 1'b1;
    logic        rst = 1'b0, we = 1'b0, ie = 1'b0;
    logic [11:0] din = '0;
    logic [9:0]  wptr, maddr;
    logic        mwe, perr, serr;
    logic [95:0] mdata;
    logic [7:0]  mmask;
    int total = 0;
    int bad = 0;

    field_wr_port dut (
        .clk(clk), .arst(arst), .wr_rst_i(rst), .wr_en_i(we), .in_en_i(ie),
        .din_i(din), .wptr_o(wptr), .mem_we_o(mwe), .mem_addr_o(maddr),
        .mem_data_o(mdata), .mem_mask_o(mmask), .proto_err_o(perr),
        .short_err_o(serr)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(logic r, logic w, logic e, logic [11:0] d);
        @(negedge clk);
        rst = r; we = w; ie = e; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic gap2();
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);
    endtask

    function automatic logic [95:0] pack8(int base);
        logic [95:0] v;
        for (int i = 0; i < 8; i++) v[i*12 +: 12] = 12'(base + i);
        return v;
    endfunction

    task automatic t_reset_state();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 ptr in reset", 96'(wptr), 0);
        @(negedge clk) arst = 1'b0;
        @(posedge clk); #1;
        chk("R1 ptr", 96'(wptr), 0);
        chk("R1 we", 96'(mwe), 0);
        chk("R1 errs", 96'({perr, serr}), 0);
        chk("R1 addr/mask", 96'({maddr, mmask}), 0);
    endtask

    task automatic t_full_blocks();
        gap2();
        tick(1, 1, 1, 12'd5);
        chk("R2 ptr cleared", 96'(wptr), 0);
        chk("R8 no short on first reset", 96'(serr), 0);
        for (int i = 0; i < 8; i++) begin
            tick(0, 1, 1, 12'(100 + i));
            chk("R3 ptr step", 96'(wptr), 96'(i + 1));
            chk("R6 no early strobe", 96'(mwe), 0);
        end
        tick(0, 1, 1, 12'd200);   // R9: write on the commit edge
        chk("R6 strobe", 96'(mwe), 1);
        chk("R6 addr", 96'(maddr), 0);
        chk("R6 mask", 96'(mmask), 96'h0ff);
        chk("R9 committed data intact", mdata, pack8(100));
        chk("R3 ptr 9", 96'(wptr), 9);
        for (int i = 1; i < 8; i++) tick(0, 1, 1, 12'(200 + i));
        chk("R3 ptr 16", 96'(wptr), 16);
        tick(0, 0, 0, 0);
        chk("R9 next block strobe", 96'(mwe), 1);
        chk("R9 next block addr", 96'(maddr), 8);
        chk("R9 next block data", mdata, pack8(200));
    endtask

    task automatic t_we_low();
        for (int i = 0; i < 3; i++) begin
            tick(0, 0, 1, 12'hfff);
            chk("R3 hold ptr", 96'(wptr), 16);
            chk("R3 no strobe", 96'(mwe), 0);
        end
    endtask

    task automatic t_in_en();
        for (int i = 0; i < 8; i++) tick(0, 1, (i % 2) == 0, 12'(500 + i));
        chk("R5 ptr advances regardless", 96'(wptr), 24);
        tick(0, 0, 0, 0);
        chk("R5 strobe", 96'(mwe), 1);
        chk("R5 mask", 96'(mmask), 96'h055);
        chk("R5 addr", 96'(maddr), 16);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 3; i++) tick(0, 1, 1, 12'(300 + i));
        tick(0, 0, 0, 0);
        chk("R7 partial held", 96'(mwe), 0);
        tick(0, 0, 0, 0);
        chk("R7 partial held", 96'(mwe), 0);
        tick(1, 1, 1, 12'd777);
        chk("R7 flush strobe", 96'(mwe), 1);
        chk("R7 flush addr", 96'(maddr), 24);
        chk("R7 flush mask", 96'(mmask), 96'h007);
        chk("R7 flush data", 96'(mdata[35:0]), 96'({12'd302, 12'd301, 12'd300}));
        chk("R2 ptr cleared, WE ignored", 96'(wptr), 0);
        chk("R8 short flagged", 96'(serr), 1);
        chk("R4 accepted, no proto err", 96'(perr), 0);
    endtask

    task automatic t_protocol();
        tick(0, 1, 1, 12'd1);
        tick(1, 1, 1, 12'd2);
        chk("R4 proto err", 96'(perr), 1);
        chk("R4 ptr not cleared, WE honored", 96'(wptr), 2);
        chk("R4 no flush", 96'(mwe), 0);
        chk("R4 no short", 96'(serr), 0);
        gap2();
        chk("R4 pulse ends", 96'(perr), 0);
        tick(1, 0, 0, 0);
        chk("R4 later reset accepted", 96'(wptr), 0);
        chk("R4 no proto err", 96'(perr), 0);
        chk("R7 flush of 2", 96'(mmask), 96'h003);
        chk("R8 short", 96'(serr), 1);
    endtask

    task automatic t_min_run();
        for (int i = 0; i < 80; i++) tick(0, 1, 0, 0);
        gap2();
        tick(1, 0, 0, 0);
        chk("R8 80 writes no short", 96'(serr), 0);
        chk("R7 aligned no flush", 96'(mwe), 0);
        for (int i = 0; i < 79; i++) tick(0, 1, 0, 0);
        gap2();
        tick(1, 0, 0, 0);
        chk("R8 79 writes short", 96'(serr), 1);
        chk("R7 flush addr 72", 96'(maddr), 72);
    endtask

    task automatic t_reset_on_commit();
        for (int i = 0; i < 8; i++) tick(0, 1, 1, 12'(400 + i));
        tick(1, 0, 0, 0);
        chk("R10 strobe", 96'(mwe), 1);
        chk("R10 addr", 96'(maddr), 0);
        chk("R10 data", mdata, pack8(400));
        chk("R10 mask", 96'(mmask), 96'h0ff);
        chk("R10 ptr", 96'(wptr), 0);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 1023; i++) tick(0, 1, 0, 0);
        chk("R3 ptr max", 96'(wptr), 1023);
        tick(0, 1, 0, 0);
        chk("R3 ptr wraps", 96'(wptr), 0);
        tick(0, 0, 0, 0);
        chk("R6 last block addr", 96'(maddr), 1016);
        chk("R6 last block strobe", 96'(mwe), 1);
    endtask

    initial begin
        t_reset_state();
        t_full_blocks();
        t_we_low();
        t_in_en();
        t_flush();
        t_protocol();
        t_min_run();
        t_reset_on_commit();
        t_wrap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule